// File: doc/BRIEF.md
# ADC Master Serial Readout Controller

This block is the serial output side of a 16-bit successive-approximation converter working as a clock master. A one-cycle start pulse begins a conversion. The conversion is modelled as a fixed count of system clock cycles. When the count ends, the block captures a parallel result word from its input. It then sends a word out on one data line and generates the serial clock, a data-valid strobe and a busy flag itself.

A mode input selects one of two readout timings. In mode 0 (read after conversion), the new result is sent as soon as the conversion ends, and busy stays high until the last bit has been sent. In mode 1 (read during conversion), the result kept from the previous conversion is sent while the new conversion runs, and busy falls when the conversion ends. The serial clock and the valid strobe each have their own polarity inversion input.

When the clock-source select is high, the master serial output is disabled. Conversions still run and still store their result, but no bits are sent.

Top module: `adc_serial_master`

## Requirements
- R1: After reset, and whenever no word is being sent, busyOut is 0 when no conversion is pending, sdataOut is 0, sclkOut equals invSclk, and validOut equals invValid.
- R2: While extClkSel is 1, a conversion produces no serial clock edges and the valid strobe stays inactive. Busy is high for exactly CONV_CYCLES cycles in both modes.
- R3: Each readout has exactly WORD_W (16) rising edges of the effective serial clock (sclkOut XOR invSclk). Bit 15 of the word is sent first and bit 0 last.
- R4: While a word is being sent, sdataOut changes only on a falling edge of the effective serial clock, so it is stable at every rising edge.
- R5: The effective valid strobe (validOut XOR invValid) is high at every rising edge of the effective serial clock. It is high for exactly 2*WORD_W*SCLK_HALF cycles per readout.
- R6: With readMode = 0, the word sent is the resultWord present when the conversion ends. Busy stays high for CONV_CYCLES + 2*WORD_W*SCLK_HALF cycles and falls in the cycle the valid strobe falls.
- R7: With readMode = 1, the word sent is the one stored by the previous conversion, and busy is high for exactly CONV_CYCLES cycles.
- R8: After reset the stored word is zero, so the first readout in readMode = 1 sends 16 zero bits.
- R9: A start pulse that arrives while busy is high, or while a word is still being sent, has no effect.
- R10: invSclk = 1 inverts sclkOut and invValid = 1 inverts validOut. Each control acts on its own output only.
- R11: The effective serial clock has a period of 2*SCLK_HALF system clock cycles, measured between consecutive rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to start a conversion |
| extClkSel | input | 1 | Clock-source select; 0 enables master serial output |
| readMode | input | 1 | 0 = read after conversion, 1 = read previous result during conversion |
| invSclk | input | 1 | Inverts the serial clock output |
| invValid | input | 1 | Inverts the valid strobe output |
| resultWord | input | 16 | Conversion result, captured when the conversion ends |
| sclkOut | output | 1 | Serial clock |
| validOut | output | 1 | Data-valid strobe |
| sdataOut | output | 1 | Serial data, most significant bit first |
| busyOut | output | 1 | Conversion / readout busy flag |

## Verification
The checker tests every cycle for the following:
- The serial clock rests at its inactive level whenever the valid strobe is off.
- The data line changes only on falling clock edges while a word is being sent.
- Every rising clock edge falls inside the valid window.
- Busy ends together with the valid strobe in mode 0 and outside any readout in mode 1.
- The valid strobe stays off in slave selection.

The bench scenarios show the rest:
- The bit order and the exact word contents.
- The previous-word hand-over and its zero after reset.
- The busy and valid lengths and the clock period.
- That start pulses arriving mid-conversion or mid-readout are ignored.
- That each polarity control inverts only its own output.

// File: rtl/adc_readout_pkg.sv
package adc_readout_pkg;

  // Strobes from the sequencer to the word datapath
  typedef struct packed {
    logic loadNew;    // copy incoming result into the shifter
    logic loadOld;    // copy stored result into the shifter
    logic latchStore; // capture incoming result into the store
    logic shiftStep;  // advance the shifter by one bit
  } dpCtrl_t;

endpackage

// File: rtl/adc_readout_dp.sv
module adc_readout_dp #(
  parameter int WORD_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  adc_readout_pkg::dpCtrl_t      ctrl,
  input  logic                          shiftActive,
  input  logic [WORD_W-1:0]             resultWord,
  output logic                          serialBit
);

  logic [WORD_W-1:0] storeQ;
  logic [WORD_W-1:0] shiftQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storeQ <= '0;
    end else if (ctrl.latchStore) begin
      storeQ <= resultWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (ctrl.loadNew) begin
      shiftQ <= resultWord;
    end else if (ctrl.loadOld) begin
      shiftQ <= storeQ;
    end else if (ctrl.shiftStep) begin
      shiftQ <= {shiftQ[WORD_W-2:0], 1'b0};
    end
  end

  assign serialBit = shiftActive & shiftQ[WORD_W-1];

endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl #(
  parameter int WORD_W      = 16,
  parameter int CONV_CYCLES = 80,
  parameter int SCLK_HALF   = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startPulse,
  input  logic                     extClkSel,
  input  logic                     readMode,
  output adc_readout_pkg::dpCtrl_t ctrl,
  output logic                     shiftActive,
  output logic                     sclkRaw,
  output logic                     busy
);

  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam int DIV_W = $clog2(SCLK_HALF + 1);
  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(SCLK_HALF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(WORD_W - 1);

  logic             convActQ;
  logic [CNT_W-1:0] convCntQ;
  logic             modeQ;
  logic             masterQ;
  logic             busyQ;
  logic             shiftActQ;
  logic [DIV_W-1:0] divCntQ;
  logic [BIT_W-1:0] bitCntQ;
  logic             sclkQ;

  logic accept, convDone, beginNew, beginOld, halfTick, fallTick, lastFall;

  assign accept   = startPulse & ~busyQ & ~shiftActQ;
  assign convDone = convActQ & (convCntQ == CONV_LAST);
  assign beginNew = convDone & ~modeQ & masterQ;
  assign beginOld = accept & readMode & ~extClkSel;
  assign halfTick = shiftActQ & (divCntQ == DIV_LAST);
  assign fallTick = halfTick & sclkQ;
  assign lastFall = fallTick & (bitCntQ == BIT_LAST);

  always_comb begin
    ctrl.loadNew    = beginNew;
    ctrl.loadOld    = beginOld;
    ctrl.latchStore = convDone;
    ctrl.shiftStep  = fallTick & ~lastFall;
  end

  // conversion timer and latched options
  always_ff @(posedge clk) begin
    if (!rstN) begin
      convActQ <= 1'b0;
      convCntQ <= '0;
      modeQ    <= 1'b0;
      masterQ  <= 1'b0;
    end else if (accept) begin
      convActQ <= 1'b1;
      convCntQ <= '0;
      modeQ    <= readMode;
      masterQ  <= ~extClkSel;
    end else if (convActQ) begin
      if (convDone) convActQ <= 1'b0;
      else          convCntQ <= convCntQ + 1'b1;
    end
  end

  // busy flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (accept) begin
      busyQ <= 1'b1;
    end else if (convDone && (modeQ || !masterQ)) begin
      busyQ <= 1'b0;
    end else if (lastFall && !modeQ) begin
      busyQ <= 1'b0;
    end
  end

  // serial clock divider and bit counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftActQ <= 1'b0;
      divCntQ   <= '0;
      bitCntQ   <= '0;
      sclkQ     <= 1'b0;
    end else if (beginNew || beginOld) begin
      shiftActQ <= 1'b1;
      divCntQ   <= '0;
      bitCntQ   <= '0;
      sclkQ     <= 1'b0;
    end else if (shiftActQ) begin
      if (halfTick) begin
        divCntQ <= '0;
        sclkQ   <= ~sclkQ;
        if (fallTick) begin
          if (lastFall) shiftActQ <= 1'b0;
          else          bitCntQ   <= bitCntQ + 1'b1;
        end
      end else begin
        divCntQ <= divCntQ + 1'b1;
      end
    end
  end

  assign shiftActive = shiftActQ;
  assign sclkRaw     = sclkQ;
  assign busy        = busyQ;

endmodule

// File: rtl/adc_serial_master.sv
module adc_serial_master #(
  parameter int WORD_W      = 16,
  parameter int CONV_CYCLES = 80,
  parameter int SCLK_HALF   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              extClkSel,
  input  logic              readMode,
  input  logic              invSclk,
  input  logic              invValid,
  input  logic [WORD_W-1:0] resultWord,
  output logic              sclkOut,
  output logic              validOut,
  output logic              sdataOut,
  output logic              busyOut
);

  adc_readout_pkg::dpCtrl_t dpCtrl;
  logic shiftActive;
  logic sclkRaw;

  adc_readout_ctrl #(
    .WORD_W(WORD_W), .CONV_CYCLES(CONV_CYCLES), .SCLK_HALF(SCLK_HALF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .extClkSel(extClkSel),
    .readMode(readMode), .ctrl(dpCtrl), .shiftActive(shiftActive),
    .sclkRaw(sclkRaw), .busy(busyOut)
  );

  adc_readout_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(dpCtrl), .shiftActive(shiftActive),
    .resultWord(resultWord), .serialBit(sdataOut)
  );

  assign sclkOut  = sclkRaw ^ invSclk;
  assign validOut = shiftActive ^ invValid;

endmodule

// File: rtl/adc_serial_master_chk.sv
module adc_serial_master_chk (
  input logic clk,
  input logic rstN,
  input logic extClkSel,
  input logic readMode,
  input logic invSclk,
  input logic invValid,
  input logic sclkOut,
  input logic validOut,
  input logic sdataOut,
  input logic busyOut
);

  logic sclkEff, validEff;
  assign sclkEff  = sclkOut ^ invSclk;
  assign validEff = validOut ^ invValid;

  // R1
  idle_sclk_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validEff |-> !sclkEff);

  // R4
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validEff && $past(validEff) && (sdataOut != $past(sdataOut))) |-> $fell(sclkEff));

  // R5
  rise_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclkEff) |-> validEff);

  // R6
  busy_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busyOut) && !readMode && !extClkSel) |-> $fell(validEff));

  // R7
  busy_during_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busyOut) && readMode) |-> !validEff);

  // R2
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (extClkSel && !validEff) |=> !validEff);

endmodule

bind adc_serial_master adc_serial_master_chk u_chk (
  .clk(clk), .rstN(rstN), .extClkSel(extClkSel), .readMode(readMode),
  .invSclk(invSclk), .invValid(invValid), .sclkOut(sclkOut),
  .validOut(validOut), .sdataOut(sdataOut), .busyOut(busyOut)
);

// File: tb/adc_serial_master_tb.sv
`timescale 1ns/1ps
module adc_serial_master_tb;

  localparam int WORD_W      = 16;
  localparam int CONV_CYCLES = 80;
  localparam int SCLK_HALF   = 2;
  localparam int SHIFT_LEN   = 2 * WORD_W * SCLK_HALF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic extClkSel = 1'b0;
  logic readMode = 1'b0;
  logic invSclk = 1'b0;
  logic invValid = 1'b0;
  logic [WORD_W-1:0] resultWord = '0;
  logic sclkOut, validOut, sdataOut, busyOut;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  adc_serial_master #(
    .WORD_W(WORD_W), .CONV_CYCLES(CONV_CYCLES), .SCLK_HALF(SCLK_HALF)
  ) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .extClkSel(extClkSel),
    .readMode(readMode), .invSclk(invSclk), .invValid(invValid),
    .resultWord(resultWord), .sclkOut(sclkOut), .validOut(validOut),
    .sdataOut(sdataOut), .busyOut(busyOut)
  );

  // negedge monitor
  logic [WORD_W-1:0] capWord;
  int rises, busyCnt, validCnt, badValid, badPeriod, cyc, lastRise;
  logic scPrev;

  always @(negedge clk) begin
    logic sc;
    sc = sclkOut ^ invSclk;
    if (sc && !scPrev) begin
      capWord = {capWord[WORD_W-2:0], sdataOut};
      rises++;
      if (!(validOut ^ invValid)) badValid++;
      if (lastRise >= 0 && (cyc - lastRise) != 2 * SCLK_HALF) badPeriod++;
      lastRise = cyc;
    end
    scPrev = sc;
    if (busyOut) busyCnt++;
    if (validOut ^ invValid) validCnt++;
    cyc++;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearMon();
    capWord = '0; rises = 0; busyCnt = 0; validCnt = 0;
    badValid = 0; badPeriod = 0; cyc = 0; lastRise = -1;
  endtask

  // run one conversion; extra start pulses during conversion and readout if asked
  task automatic runConv(input logic mode, input logic [WORD_W-1:0] word, input bit extra);
    @(posedge clk); #1;
    readMode = mode; resultWord = word;
    clearMon();
    startPulse = 1'b1;
    @(posedge clk); #1;
    startPulse = 1'b0;
    for (int i = 0; i < CONV_CYCLES + SHIFT_LEN + 20; i++) begin
      if (extra && (i == 10 || i == CONV_CYCLES + 10 || i == CONV_CYCLES + 40))
        startPulse = 1'b1;
      @(posedge clk); #1;
      startPulse = 1'b0;
    end
  endtask

  task automatic testReset();
    check(busyOut == 1'b0, "R1 busy after reset", busyOut, 0);
    check(sdataOut == 1'b0, "R1 sdata idle", sdataOut, 0);
    check(sclkOut == invSclk, "R1 sclk idle", sclkOut, invSclk);
    check(validOut == invValid, "R1 valid idle", validOut, invValid);
  endtask

  task automatic testFirstDuring();
    runConv(1'b1, 16'hA1B2, 1'b0);
    check(capWord == 16'h0000, "R8 first during-read zero", capWord, 0);
    check(busyCnt == CONV_CYCLES, "R7 busy length during", busyCnt, CONV_CYCLES);
    check(rises == WORD_W, "R3 edge count", rises, WORD_W);
  endtask

  task automatic testSecondDuring();
    runConv(1'b1, 16'h3C4D, 1'b0);
    check(capWord == 16'hA1B2, "R7 previous word sent", capWord, 16'hA1B2);
    check(validCnt == SHIFT_LEN, "R5 valid length", validCnt, SHIFT_LEN);
  endtask

  task automatic testAfter();
    runConv(1'b0, 16'h5E6F, 1'b0);
    check(capWord == 16'h5E6F, "R6 new word sent", capWord, 16'h5E6F);
    check(busyCnt == CONV_CYCLES + SHIFT_LEN, "R6 busy length", busyCnt, CONV_CYCLES + SHIFT_LEN);
    check(rises == WORD_W, "R3 edge count after", rises, WORD_W);
    check(badPeriod == 0, "R11 sclk period", badPeriod, 0);
    check(badValid == 0, "R5 valid at rises", badValid, 0);
  endtask

  task automatic testMsbOrder();
    runConv(1'b0, 16'h8001, 1'b0);
    check(capWord == 16'h8001, "R3 msb first", capWord, 16'h8001);
  endtask

  task automatic testPolarity();
    @(posedge clk); #1;
    invSclk = 1'b1; invValid = 1'b0;
    #2;
    check(sclkOut == 1'b1 && validOut == 1'b0, "R10 sclk inverted only",
          {sclkOut, validOut}, 2'b10);
    runConv(1'b0, 16'hC35A, 1'b0);
    check(capWord == 16'hC35A && rises == WORD_W, "R10 word with sclk inverted", capWord, 16'hC35A);
    @(posedge clk); #1;
    invSclk = 1'b0; invValid = 1'b1;
    #2;
    check(sclkOut == 1'b0 && validOut == 1'b1, "R10 valid inverted only",
          {sclkOut, validOut}, 2'b01);
    runConv(1'b0, 16'h0F0F, 1'b0);
    check(capWord == 16'h0F0F && validCnt == SHIFT_LEN, "R10 word with valid inverted",
          capWord, 16'h0F0F);
    @(posedge clk); #1;
    invValid = 1'b0;
  endtask

  task automatic testIgnoreStart();
    runConv(1'b0, 16'h7E81, 1'b1);
    check(busyCnt == CONV_CYCLES + SHIFT_LEN, "R9 busy not extended", busyCnt, CONV_CYCLES + SHIFT_LEN);
    check(rises == WORD_W, "R9 single readout", rises, WORD_W);
    check(capWord == 16'h7E81, "R9 word intact", capWord, 16'h7E81);
  endtask

  task automatic testSlave();
    @(posedge clk); #1;
    extClkSel = 1'b1;
    runConv(1'b0, 16'hBEEF, 1'b0);
    check(rises == 0, "R2 no sclk edges", rises, 0);
    check(validCnt == 0, "R2 valid quiet", validCnt, 0);
    check(busyCnt == CONV_CYCLES, "R2 busy length", busyCnt, CONV_CYCLES);
    @(posedge clk); #1;
    extClkSel = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    clearMon();
    scPrev = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    testReset();
    testFirstDuring();
    testSecondDuring();
    testAfter();
    testMsbOrder();
    testPolarity();
    testIgnoreStart();
    testSlave();
    testReset();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule